// File: doc/BRIEF.md
# Partitioned SIMD Lane Adder

This block adds two 32-bit words through a single carry chain that can be cut at byte boundaries, so the same hardware performs one 32-bit addition, two independent 16-bit additions or four independent 8-bit additions in one cycle. A 2-bit mode input, shared by every lane, chooses the partitioning for the whole word. The operands and the packed sum are always one full word wide. Lane i of width W occupies bits [W*i+W-1 : W*i].

Every lane wraps modulo its own width and reports its own carry-out in a 4-bit carry vector. One register stage sits between inputs and outputs, and a valid flag travels with the data. When no valid input arrives, the registered result stays as it was.

Top module: `simd_lane_adder`

## Requirements
- R1: With mode 00, sum_out is (a_in + b_in) mod 2^32, and carry_out[0] is the carry out of bit 31.
- R2: With mode 01, bits [15:0] and bits [31:16] are added as separate 16-bit lanes, and no carry passes from bit 15 into bit 16. carry_out[0] is the low lane's carry and carry_out[1] is the high lane's carry.
- R3: With mode 10, each byte i (bits [8i+7:8i]) is added as a separate 8-bit lane, and no carry crosses any byte boundary. carry_out[i] is the carry of byte lane i.
- R4: Mode 11 is reserved and gives exactly the same result and carry as mode 00.
- R5: Each lane wraps modulo 2 to the power of its width. For example, 0xFF + 0x01 in an 8-bit lane gives 0x00 with a carry of 1.
- R6: Carry bits that belong to no lane are zero: carry_out[3:1] in modes 00 and 11, and carry_out[3:2] in mode 01.
- R7: sum_out and carry_out show the result of an input that was accepted on a rising clock edge with valid_in high, starting from that edge. valid_out equals the valid_in sampled at the previous edge.
- R8: At an edge where valid_in is low, sum_out and carry_out keep their values, whatever is on the operand and mode inputs.
- R9: While rst_n is low, valid_out, sum_out and carry_out are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| valid_in | input | 1 | Operands and mode are valid this cycle |
| mode_in | input | 2 | Partitioning: 00 = 1x32, 01 = 2x16, 10 = 4x8, 11 = treated as 1x32 |
| a_in | input | 32 | First packed operand |
| b_in | input | 32 | Second packed operand |
| valid_out | output | 1 | Registered result is from a valid input |
| sum_out | output | 32 | Packed lane sums |
| carry_out | output | 4 | Carry-out for each lane, unused bits zero |

## Verification
The assertions check on every cycle that valid_out follows valid_in one cycle later, that the result registers hold while the input is idle, that unused carry bits stay zero in the wide modes, and that every cut segment adds without any carry from below. Only the bench's vectors can show that the full-word sums and carries are correct in each mode, and that the reserved mode behaves exactly like the 32-bit mode. They do this with operands that generate carries right at bit 7 and bit 15. The reset values are also checked by the bench alone.

// File: rtl/simd_add_pkg.sv
package simd_add_pkg;

   typedef enum logic [1:0] {
      MODE_W32 = 2'b00,
      MODE_W16 = 2'b01,
      MODE_W8  = 2'b10,
      MODE_RSV = 2'b11
   } lane_mode_e;

endpackage

// File: rtl/lane_cut_ctrl.sv
module lane_cut_ctrl
   import simd_add_pkg::*;
#(
   parameter int NUM_SEG = 4
) (
   input  lane_mode_e         mode,
   output logic [NUM_SEG-1:0] cut
);
   localparam int HALF = NUM_SEG / 2;

   generate
      for (genvar i = 0; i < NUM_SEG; i++) begin : g_cut
         if (i == 0) begin : g_base
            assign cut[i] = 1'b1;
         end else if (i == HALF) begin : g_mid
            assign cut[i] = (mode == MODE_W16) || (mode == MODE_W8);
         end else begin : g_byte
            assign cut[i] = (mode == MODE_W8);
         end
      end
   endgenerate

endmodule

// File: rtl/seg_chain.sv
module seg_chain #(
   parameter int SEG_W   = 8,
   parameter int NUM_SEG = 4
) (
   input  logic [SEG_W*NUM_SEG-1:0] a,
   input  logic [SEG_W*NUM_SEG-1:0] b,
   input  logic [NUM_SEG-1:0]       cut,
   output logic [SEG_W*NUM_SEG-1:0] sum,
   output logic [NUM_SEG-1:0]       seg_cout
);
   generate
      for (genvar i = 0; i < NUM_SEG; i++) begin : g_seg
         logic [SEG_W-1:0] a_s;
         logic [SEG_W-1:0] b_s;
         logic             cin;
         logic [SEG_W:0]   res;

         assign a_s = a[i*SEG_W +: SEG_W];
         assign b_s = b[i*SEG_W +: SEG_W];

         if (i == 0) begin : g_first
            assign cin = 1'b0;
         end else begin : g_next
            assign cin = cut[i] ? 1'b0 : g_seg[i-1].res[SEG_W];
         end

         assign res = {1'b0, a_s} + {1'b0, b_s} + {{SEG_W{1'b0}}, cin};
         assign sum[i*SEG_W +: SEG_W] = res[SEG_W-1:0];
         assign seg_cout[i] = res[SEG_W];

         always_comb begin
            if (!$isunknown({cut[i], a_s, b_s}) && cut[i]) begin
               AST_SEG_ISOLATED: assert (sum[i*SEG_W +: SEG_W] == SEG_W'(a_s + b_s)) // R3
                  else $error("cut segment %0d received a carry", i);
            end
         end
      end
   endgenerate

endmodule

// File: rtl/carry_pick.sv
module carry_pick
   import simd_add_pkg::*;
#(
   parameter int NUM_SEG = 4
) (
   input  lane_mode_e         mode,
   input  logic [NUM_SEG-1:0] seg_cout,
   output logic [NUM_SEG-1:0] carry_vec
);
   localparam int HALF = NUM_SEG / 2;

   always_comb begin
      carry_vec = '0;
      unique case (mode)
         MODE_W8: carry_vec = seg_cout;
         MODE_W16: begin
            carry_vec[0] = seg_cout[HALF-1];
            carry_vec[1] = seg_cout[NUM_SEG-1];
         end
         default: carry_vec[0] = seg_cout[NUM_SEG-1];
      endcase
   end

endmodule

// File: rtl/simd_lane_adder.sv
module simd_lane_adder
   import simd_add_pkg::*;
#(
   parameter int SEG_W   = 8,
   parameter int NUM_SEG = 4,
   localparam int DATA_W = SEG_W * NUM_SEG
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              valid_in,
   input  logic [1:0]        mode_in,
   input  logic [DATA_W-1:0] a_in,
   input  logic [DATA_W-1:0] b_in,
   output logic              valid_out,
   output logic [DATA_W-1:0] sum_out,
   output logic [NUM_SEG-1:0] carry_out
);

   generate
      if (NUM_SEG < 4 || (NUM_SEG & (NUM_SEG - 1)) != 0) begin : g_bad_seg
         $error("NUM_SEG must be a power of two of at least 4");
      end
      if (SEG_W < 1) begin : g_bad_w
         $error("SEG_W must be positive");
      end
   endgenerate

   lane_mode_e           mode_e;
   logic [NUM_SEG-1:0]   cut;
   logic [NUM_SEG-1:0]   seg_cout;
   logic [NUM_SEG-1:0]   carry_d;
   logic [DATA_W-1:0]    sum_d;

   assign mode_e = lane_mode_e'(mode_in);

   lane_cut_ctrl #(.NUM_SEG(NUM_SEG)) cut_i (
      .mode (mode_e),
      .cut  (cut)
   );

   seg_chain #(.SEG_W(SEG_W), .NUM_SEG(NUM_SEG)) chain_i (
      .a        (a_in),
      .b        (b_in),
      .cut      (cut),
      .sum      (sum_d),
      .seg_cout (seg_cout)
   );

   carry_pick #(.NUM_SEG(NUM_SEG)) pick_i (
      .mode      (mode_e),
      .seg_cout  (seg_cout),
      .carry_vec (carry_d)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_out <= 1'b0;
         sum_out   <= '0;
         carry_out <= '0;
      end else begin
         valid_out <= valid_in;
         if (valid_in) begin
            sum_out   <= sum_d;
            carry_out <= carry_d;
         end
      end
   end

   AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      valid_in |=> valid_out) else $error("valid_out missed"); // R7
   AST_VALID_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      !valid_in |=> !valid_out) else $error("valid_out spurious"); // R7
   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !valid_in |=> ($stable(sum_out) && $stable(carry_out))) else $error("result moved while idle"); // R8
   AST_W16_SPARE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_in && mode_in == 2'b01) |=> (carry_out[NUM_SEG-1:2] == '0)) else $error("spare carry set"); // R6
   AST_W32_SPARE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_in && (mode_in == 2'b00 || mode_in == 2'b11)) |=> (carry_out[NUM_SEG-1:1] == '0)) else $error("spare carry set"); // R6

endmodule

// File: tb/simd_lane_adder_tb.sv
`timescale 1ns/1ps
module simd_lane_adder_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        valid_in = 1'b0;
   logic [1:0]  mode_in = 2'b00;
   logic [31:0] a_in = '0;
   logic [31:0] b_in = '0;
   logic        valid_out;
   logic [31:0] sum_out;
   logic [3:0]  carry_out;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   simd_lane_adder dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .valid_in  (valid_in),
      .mode_in   (mode_in),
      .a_in      (a_in),
      .b_in      (b_in),
      .valid_out (valid_out),
      .sum_out   (sum_out),
      .carry_out (carry_out)
   );

   // {mode, a, b, expected sum, expected carry}
   localparam logic [101:0] VEC [12] = '{
      {2'b00, 32'hFFFF_FFFF, 32'h0000_0001, 32'h0000_0000, 4'h1}, // R1 R5
      {2'b01, 32'hFFFF_FFFF, 32'h0000_0001, 32'hFFFF_0000, 4'h1}, // R2 R5
      {2'b10, 32'hFFFF_FFFF, 32'h0000_0001, 32'hFFFF_FF00, 4'h1}, // R3 R5
      {2'b10, 32'h80FF_7F01, 32'h8001_7F01, 32'h0000_FE02, 4'hC}, // R3
      {2'b01, 32'h80FF_7F01, 32'h8001_7F01, 32'h0100_FE02, 4'h2}, // R2
      {2'b00, 32'h80FF_7F01, 32'h8001_7F01, 32'h0100_FE02, 4'h1}, // R1
      {2'b11, 32'h80FF_7F01, 32'h8001_7F01, 32'h0100_FE02, 4'h1}, // R4
      {2'b10, 32'h1234_5678, 32'h1111_1111, 32'h2345_6789, 4'h0}, // R3
      {2'b01, 32'h0000_FFFF, 32'h0000_FFFF, 32'h0000_FFFE, 4'h1}, // R2 R6
      {2'b00, 32'h0000_FFFF, 32'h0000_FFFF, 32'h0001_FFFE, 4'h0}, // R1 R6
      {2'b10, 32'h00FF_00FF, 32'h00FF_00FF, 32'h00FE_00FE, 4'h5}, // R3
      {2'b01, 32'h00FF_00FF, 32'h00FF_00FF, 32'h01FE_01FE, 4'h0}  // R2
   };

   function automatic string tag_of(input logic [1:0] m);
      case (m)
         2'b00:   return "R1";
         2'b01:   return "R2";
         2'b10:   return "R3";
         default: return "R4";
      endcase
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic apply(input logic [1:0] m, input logic [31:0] a, input logic [31:0] b);
      @(negedge clk);
      mode_in  = m;
      a_in     = a;
      b_in     = b;
      valid_in = 1'b1;
      @(negedge clk);
      valid_in = 1'b0;
   endtask

   initial begin
      // R9: reset state
      #20;
      check("R9 valid", {31'b0, valid_out}, 32'h0);
      check("R9 sum", sum_out, 32'h0);
      check("R9 carry", {28'b0, carry_out}, 32'h0);
      @(negedge clk);
      rst_n = 1'b1;

      for (int i = 0; i < 12; i++) begin
         apply(VEC[i][101:100], VEC[i][99:68], VEC[i][67:36]);
         check({tag_of(VEC[i][101:100]), " R5 sum"}, sum_out, VEC[i][35:4]);
         check({tag_of(VEC[i][101:100]), " R6 carry"}, {28'b0, carry_out}, {28'b0, VEC[i][3:0]});
         check("R7 valid high", {31'b0, valid_out}, 32'h1);
      end

      // R7: valid drops one cycle after valid_in drops
      @(negedge clk);
      check("R7 valid low", {31'b0, valid_out}, 32'h0);

      // R8: idle inputs change nothing (last result 01FE01FE, carry 0)
      mode_in = 2'b10;
      a_in    = 32'hFFFF_FFFF;
      b_in    = 32'hFFFF_FFFF;
      @(negedge clk);
      @(negedge clk);
      check("R8 sum held", sum_out, 32'h01FE_01FE);
      check("R8 carry held", {28'b0, carry_out}, 32'h0);

      // R3 R5: all bytes overflow at once
      apply(2'b10, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
      check("R3 R5 sum", sum_out, 32'hFEFE_FEFE);
      check("R3 carry", {28'b0, carry_out}, 32'hF);

      // R4: reserved mode with carry out of bit 31 only
      apply(2'b11, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
      check("R4 sum", sum_out, 32'hFFFF_FFFE);
      check("R4 R6 carry", {28'b0, carry_out}, 32'h1);

      // R9: reset clears a loaded result
      @(negedge clk);
      rst_n = 1'b0;
      #1;
      check("R9 sum cleared", sum_out, 32'h0);
      check("R9 carry cleared", {28'b0, carry_out}, 32'h0);
      @(negedge clk);
      rst_n = 1'b1;

      if (!done) begin
         done = 1'b1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog actual timeout expected completion");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule